// File: doc/BRIEF.md
# DDR Command Spacing Checker

This block watches the command pins of a DDR SDRAM interface and reports commands that arrive sooner than the bank-state, burst and latency rules permit. It never drives the memory. It decodes chip select, the three strobe pins and the bank address on every clock. From those it keeps an open or idle state and an activation age for each bank. It also keeps the age and kind of the most recent column command, shared across all banks.

A Read or Write is judged against several rules. The addressed bank must be open. The row-to-column delay must have elapsed since that bank's Activate. A minimum column-to-column spacing must hold. A Write that follows a Read must also wait for the read data to clear the bus. This wait is the read's CAS latency plus half the burst length, rounded up to whole clocks. Because of that rounding, a half-cycle latency such as 2.5 adds a full clock. A Read that arrives before the earlier burst has finished is treated as a legal cut-off of that burst, provided the column spacing holds. An Activate to a bank that is already open is also flagged.

Burst length (in beats) and CAS latency (in half clocks) are inputs, so one instance can follow a mode change. Each offending command produces a one-cycle flag with a code that names the broken rule.

Top module: `ddr_cmd_spacing_chk`

## Requirements
- R1: Commands are decoded with `cs_n` low, from {`ras_n`,`cas_n`,`we_n`}: 011 Activate, 101 Read, 100 Write, 010 Precharge, 110 Burst Stop, 111 No-op, and 001/000 other. When `cs_n` is high the pins are a deselect and change no state, whatever the other pins carry.
- R2: A Read or Write to a bank that is idle is flagged with code 1.
- R3: A Read or Write to an open bank fewer than T_RCD clocks after that bank's Activate is flagged with code 2. At exactly T_RCD clocks it is legal, and an Activate to a different bank has no effect on this rule.
- R4: An Activate to a bank that is already open is flagged with code 3. An Activate to an idle bank opens it with no flag.
- R5: A Read or Write fewer than T_CCD clocks after the previous Read or Write (any bank) is flagged with code 4. A Read at T_CCD clocks or more is legal even when it cuts off a burst still in progress (sooner than BL/2 clocks).
- R6: A Write fewer than ceil((cfg_cl_half + cfg_bl)/2) clocks after a Read is flagged with code 5, with `cfg_bl` in beats and `cfg_cl_half` in half clocks. At exactly that spacing it is legal, for both whole-cycle and half-cycle latencies.
- R7: A Precharge returns its bank to idle. A later Read to that bank is flagged with code 1, and a later Activate to it is not flagged.
- R8: When several rules fail on one command, a single code is reported by priority: bank state (1 or 3) first, then code 2, then code 4, then code 5.
- R9: After reset all banks are idle and no flag is raised. A flag appears in the clock after the offending command, lasts one cycle, and `viol_code` is 0 whenever `viol_valid` is low.
- R10: No-op, Burst Stop, refresh and mode-set commands raise no flag and leave every bank's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address of the command |
| cfg_bl | input | BL_W | Burst length in beats |
| cfg_cl_half | input | CL_W | CAS latency in half clocks |
| viol_valid | output | 1 | One-cycle violation flag |
| viol_code | output | 3 | Code of the broken rule, 0 when no flag |

## Verification
The hardest situation to reach is a single command that breaks several rules at once, because the priority order only shows up then. To get there, the stimulus first closes a bank and then re-activates it. It then issues a Read to another, open bank in the next clock. One clock later it issues a Read to the re-activated bank, which breaks both the row-to-column delay and the column spacing. A Read to a never-opened bank follows at once, adding an idle-bank error on top of the spacing error. The write-after-read boundary is probed one clock on each side of the rounded limit, for a whole-cycle latency and again for a half-cycle latency.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_READ  = 3'd3,
        CMD_WRITE = 3'd4,
        CMD_PRE   = 3'd5,
        CMD_BST   = 3'd6,
        CMD_OTHER = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        VC_NONE     = 3'd0,
        VC_IDLE     = 3'd1,
        VC_RCD      = 3'd2,
        VC_ACT_OPEN = 3'd3,
        VC_CCD      = 3'd4,
        VC_RTW      = 3'd5
    } viol_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b010:  cmd = CMD_PRE;
                3'b110:  cmd = CMD_BST;
                3'b111:  cmd = CMD_NOP;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_chk_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int T_RCD = 3,
    parameter int AGE_W = 6,
    localparam int NUM_BANKS = 1 << BA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_e                 cmd,
    input  logic [BA_W-1:0]      ba,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [NUM_BANKS-1:0] rcd_met
);

    localparam logic [AGE_W-1:0] AGE_MAX = '1;
    localparam logic [AGE_W-1:0] RCD_LIM = AGE_W'(T_RCD);

    typedef struct packed {
        logic             open;
        logic [AGE_W-1:0] age;
    } bank_s;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [BA_W-1:0] MY_BA = BA_W'(g);
        bank_s st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (st_q.age != AGE_MAX) begin
                st_d.age = st_q.age + 1'b1;
            end
            if (ba == MY_BA) begin
                if (cmd == CMD_ACT) begin
                    st_d.open = 1'b1;
                    st_d.age  = AGE_W'(1);
                end else if (cmd == CMD_PRE) begin
                    st_d.open = 1'b0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= '{open: 1'b0, age: AGE_MAX};
            end else begin
                st_q <= st_d;
            end
        end

        assign bank_open[g] = st_q.open;
        assign rcd_met[g]   = (st_q.age >= RCD_LIM);

        p_pre_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_PRE && ba == MY_BA) |=> !bank_open[g]);

        p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_ACT && ba == MY_BA) |=> bank_open[g]);

        p_rcd_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (T_RCD > 1 && cmd == CMD_ACT && ba == MY_BA) |=> !rcd_met[g]);
    end

endmodule

// File: rtl/ddr_col_spacing.sv
module ddr_col_spacing
    import ddr_chk_pkg::*;
#(
    parameter int T_CCD = 2,
    parameter int AGE_W = 6,
    parameter int BL_W  = 4,
    parameter int CL_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cmd_e            cmd,
    input  logic [BL_W-1:0] cfg_bl,
    input  logic [CL_W-1:0] cfg_cl_half,
    output logic            ccd_ok,
    output logic            rtw_ok
);

    localparam int SUM_W = ((BL_W > CL_W) ? BL_W : CL_W) + 1;
    localparam int CMP_W = (AGE_W > SUM_W) ? AGE_W : SUM_W;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;
    localparam logic [AGE_W-1:0] CCD_LIM = AGE_W'(T_CCD);

    typedef struct packed {
        logic             seen;
        logic             last_rd;
        logic [AGE_W-1:0] age;
    } col_s;

    col_s st_d, st_q;
    logic [SUM_W-1:0] rtw_sum;
    logic [SUM_W-1:0] rtw_need;

    // Half-clock sum of latency and burst, rounded up to whole clocks.
    assign rtw_sum  = SUM_W'(cfg_cl_half) + SUM_W'(cfg_bl) + SUM_W'(1);
    assign rtw_need = rtw_sum >> 1;

    always_comb begin
        st_d = st_q;
        if (st_q.age != AGE_MAX) begin
            st_d.age = st_q.age + 1'b1;
        end
        if (cmd == CMD_READ || cmd == CMD_WRITE) begin
            st_d.seen    = 1'b1;
            st_d.last_rd = (cmd == CMD_READ);
            st_d.age     = AGE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{seen: 1'b0, last_rd: 1'b0, age: AGE_MAX};
        end else begin
            st_q <= st_d;
        end
    end

    assign ccd_ok = !st_q.seen || (st_q.age >= CCD_LIM);
    assign rtw_ok = !st_q.seen || !st_q.last_rd
                    || (CMP_W'(st_q.age) >= CMP_W'(rtw_need));

    p_ccd_after_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (T_CCD > 1 && (cmd == CMD_READ || cmd == CMD_WRITE)) |=> !ccd_ok);

    p_rtw_after_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ) |=> (!rtw_ok || rtw_need <= SUM_W'(1)));

    p_write_clears_rtw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE) |=> rtw_ok);

endmodule

// File: rtl/ddr_cmd_spacing_chk.sv
module ddr_cmd_spacing_chk
    import ddr_chk_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int BL_W  = 4,
    parameter int CL_W  = 4,
    parameter int T_RCD = 3,
    parameter int T_CCD = 2,
    parameter int AGE_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic [BL_W-1:0] cfg_bl,
    input  logic [CL_W-1:0] cfg_cl_half,
    output logic            viol_valid,
    output logic [2:0]      viol_code
);

    localparam int NUM_BANKS = 1 << BA_W;

    typedef struct packed {
        logic  valid;
        viol_e code;
    } out_s;

    cmd_e                 cmd;
    logic [NUM_BANKS-1:0] bank_open;
    logic [NUM_BANKS-1:0] rcd_met;
    logic                 ccd_ok;
    logic                 rtw_ok;
    out_s                 out_d, out_q;

    ddr_cmd_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    ddr_bank_tracker #(
        .BA_W  (BA_W),
        .T_RCD (T_RCD),
        .AGE_W (AGE_W)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .ba        (ba),
        .bank_open (bank_open),
        .rcd_met   (rcd_met)
    );

    ddr_col_spacing #(
        .T_CCD (T_CCD),
        .AGE_W (AGE_W),
        .BL_W  (BL_W),
        .CL_W  (CL_W)
    ) u_col (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .cfg_bl      (cfg_bl),
        .cfg_cl_half (cfg_cl_half),
        .ccd_ok      (ccd_ok),
        .rtw_ok      (rtw_ok)
    );

    // Rule priority: bank state, row-to-column, column spacing, read-to-write.
    always_comb begin
        out_d = '{valid: 1'b0, code: VC_NONE};
        case (cmd)
            CMD_ACT: begin
                if (bank_open[ba]) begin
                    out_d.code = VC_ACT_OPEN;
                end
            end
            CMD_READ, CMD_WRITE: begin
                if (!bank_open[ba]) begin
                    out_d.code = VC_IDLE;
                end else if (!rcd_met[ba]) begin
                    out_d.code = VC_RCD;
                end else if (!ccd_ok) begin
                    out_d.code = VC_CCD;
                end else if (cmd == CMD_WRITE && !rtw_ok) begin
                    out_d.code = VC_RTW;
                end
            end
            default: out_d.code = VC_NONE;
        endcase
        out_d.valid = (out_d.code != VC_NONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{valid: 1'b0, code: VC_NONE};
        end else begin
            out_q <= out_d;
        end
    end

    assign viol_valid = out_q.valid;
    assign viol_code  = out_q.code;

    p_code_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_valid |-> (viol_code == 3'd0));

    p_idle_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_READ || cmd == CMD_WRITE) && !bank_open[ba])
        |=> (viol_valid && viol_code == 3'd1));

    p_act_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && bank_open[ba]) |=> (viol_code == 3'd3));

    p_quiet_cmds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP || cmd == CMD_BST || cmd == CMD_OTHER || cmd == CMD_DESEL)
        |=> !viol_valid);

endmodule

// File: tb/ddr_cmd_spacing_chk_tb_top.sv
module ddr_cmd_spacing_chk_tb_top;

    localparam int OP_NOP = 0, OP_ACT = 1, OP_RD = 2, OP_WR = 3, OP_PRE = 4,
                   OP_BST = 5, OP_REF = 6, OP_MRS = 7, OP_DESEL_ACT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [3:0] cfg_bl = 4'd8;
    logic [3:0] cfg_cl_half = 4'd4;
    logic       viol_valid;
    logic [2:0] viol_code;

    typedef struct {
        logic [2:0] code;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    ddr_cmd_spacing_chk dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .ba          (ba),
        .cfg_bl      (cfg_bl),
        .cfg_cl_half (cfg_cl_half),
        .viol_valid  (viol_valid),
        .viol_code   (viol_code)
    );

    task automatic op(input int kind, input logic [1:0] b, input logic [2:0] code,
                      input string tag);
        exp_t e;
        @(negedge clk);
        cs_n = 1'b0;
        ba   = b;
        case (kind)
            OP_ACT:       {ras_n, cas_n, we_n} = 3'b011;
            OP_RD:        {ras_n, cas_n, we_n} = 3'b101;
            OP_WR:        {ras_n, cas_n, we_n} = 3'b100;
            OP_PRE:       {ras_n, cas_n, we_n} = 3'b010;
            OP_BST:       {ras_n, cas_n, we_n} = 3'b110;
            OP_REF:       {ras_n, cas_n, we_n} = 3'b001;
            OP_MRS:       {ras_n, cas_n, we_n} = 3'b000;
            OP_DESEL_ACT: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b011; end
            default:      {ras_n, cas_n, we_n} = 3'b111;
        endcase
        e.code = code;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) op(OP_NOP, 2'd0, 3'd0, "R9");
    endtask

    // Monitor: the flag for a command driven at a falling edge is
    // registered at the next rising edge; compare just after it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                exp_t e;
                logic exp_v;
                e = exp_q.pop_front();
                exp_v = (e.code != 3'd0);
                checks++;
                if (viol_valid !== exp_v || viol_code !== e.code) begin
                    errors++;
                    $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
                             e.tag, viol_valid, viol_code, exp_v, e.code);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R9: watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (viol_valid !== 1'b0 || viol_code !== 3'd0) begin
            errors++;
            $display("FAIL R9: reset valid=%0b code=%0d expected valid=0 code=0",
                     viol_valid, viol_code);
        end
        rst_n = 1'b1;

        // R2: column commands to idle banks
        op(OP_RD, 2'd0, 3'd1, "R2");
        nops(4);
        op(OP_WR, 2'd1, 3'd1, "R2");
        nops(4);

        // R1: deselected Activate must not open bank 0
        op(OP_DESEL_ACT, 2'd0, 3'd0, "R1");
        op(OP_RD, 2'd0, 3'd1, "R1");
        nops(4);

        // R3: row-to-column delay, then legal at exactly T_RCD=3
        op(OP_ACT, 2'd0, 3'd0, "R4");
        op(OP_RD, 2'd0, 3'd2, "R3");
        nops(1);
        op(OP_RD, 2'd0, 3'd0, "R3");

        // R4: activate an open bank
        op(OP_ACT, 2'd0, 3'd3, "R4");
        nops(4);

        // R3 other bank activate irrelevant; R5 spacing and burst cut-off
        op(OP_ACT, 2'd1, 3'd0, "R4");
        op(OP_RD, 2'd0, 3'd0, "R3");
        op(OP_RD, 2'd0, 3'd4, "R5");
        nops(1);
        op(OP_RD, 2'd1, 3'd0, "R5");
        nops(6);

        // R6: BL=8, CL=2.0 -> 6 clocks
        op(OP_RD, 2'd0, 3'd0, "R6");
        nops(4);
        op(OP_WR, 2'd1, 3'd5, "R6");
        nops(6);
        op(OP_RD, 2'd0, 3'd0, "R6");
        nops(5);
        op(OP_WR, 2'd1, 3'd0, "R6");
        op(OP_WR, 2'd0, 3'd4, "R5");
        nops(6);

        // R6: BL=8, CL=2.5 -> 7 clocks
        cfg_cl_half = 4'd5;
        op(OP_RD, 2'd0, 3'd0, "R6");
        nops(5);
        op(OP_WR, 2'd1, 3'd5, "R6");
        nops(7);
        op(OP_RD, 2'd0, 3'd0, "R6");
        nops(6);
        op(OP_WR, 2'd1, 3'd0, "R6");
        nops(6);

        // R7 and R8: reopen bank 1, then multi-rule commands
        op(OP_PRE, 2'd1, 3'd0, "R7");
        nops(4);
        op(OP_ACT, 2'd1, 3'd0, "R7");
        op(OP_RD, 2'd0, 3'd0, "R8");
        op(OP_RD, 2'd1, 3'd2, "R8");
        op(OP_RD, 2'd2, 3'd1, "R8");
        nops(6);

        // R7: precharge closes bank 0
        op(OP_PRE, 2'd0, 3'd0, "R7");
        nops(3);
        op(OP_RD, 2'd0, 3'd1, "R7");
        op(OP_ACT, 2'd0, 3'd0, "R7");
        nops(4);

        // R10: quiet commands keep bank 0 open
        op(OP_BST, 2'd0, 3'd0, "R10");
        op(OP_REF, 2'd0, 3'd0, "R10");
        op(OP_MRS, 2'd0, 3'd0, "R10");
        op(OP_RD, 2'd0, 3'd0, "R10");
        op(OP_ACT, 2'd0, 3'd3, "R10");
        nops(3);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule